// File: doc/BRIEF.md
# Dual Wiper Register Bank

This block keeps the digital state of a two-channel digital potentiometer. Each channel owns one volatile wiper code register, which selects a single tap along a resistor string, and a small bank of data registers that stand in for nonvolatile storage. A serial front end, outside this block, decodes commands into single-cycle operation strobes carrying an opcode, a channel index, a register index and a data byte. The block executes those strobes. It can write and read the wiper codes, copy between a channel's wiper and one of its data registers, and copy between both wipers and the data register at the same index in every channel.

Writes into the data registers follow the timing of a nonvolatile cell. A data-register write or transfer is only recorded while the command is in progress, with chip select low. The timed write cycle starts in the clock after chip select returns high. For its whole length a write-in-progress flag is raised, and the new value lands when the flag drops. An active-low write-protect input blocks data-register writes and leaves wiper writes untouched. Dropping write protect before the cycle starts cancels a recorded write, and dropping it after the cycle has started has no effect. After reset, each wiper is reloaded from data register 0 of its own channel. The data registers keep their contents through reset.

Top module: `dual_wiper_bank`

## Requirements
- R1: Three clocks after `rst_n` rises, each channel's wiper code equals that channel's data register 0, which keeps its contents through reset. `wip` is 0 and `rd_data` is 0 after reset.
- R2: Opcode 1 (write wiper) with chip select low loads `wr_data` into the wiper of channel `pot_sel` at the next clock edge. The other channel is unchanged. This works whatever the state of `wp_n` and `wip`.
- R3: Opcode 3 (write data register) records its write while `cs_n` is low. Reads of that register return the old value until the write completes. `wip` is 1 for exactly WR_CYCLES clocks, starting in the clock after `cs_n` is sampled high. The new value is readable once `wip` is 0 again.
- R4: Opcode 4 copies data register `reg_sel` of channel `pot_sel` into that channel's wiper at the next edge. Opcode 5 copies that channel's wiper into its data register `reg_sel` through a timed write cycle.
- R5: Opcode 6 loads each wiper from its own channel's data register `reg_sel`. Opcode 7 stores each wiper into its own channel's data register `reg_sel` in one timed write cycle.
- R6: A data-register request made while `wp_n` is 0 is dropped. If `wp_n` is 0 at any clock between recording the request and the clock where `cs_n` is sampled high, the write is cancelled. In both cases `wip` stays 0 and the register keeps its contents.
- R7: Once `wip` is 1, driving `wp_n` low does not stop the write, and the new value is stored.
- R8: A data-register request issued while `wip` is 1 is ignored. No second cycle follows and the register keeps the first write's value.
- R9: For channel p, `tap_sel[p*256 + code]` is the only bit set in that channel's 256-bit field, where code is the channel's wiper code. This holds from code 0 through code 255.
- R10: Opcode 0 returns the selected wiper and opcode 2 returns the selected data register on `rd_data` after the next edge. Any strobe given while `cs_n` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; a rising edge starts a recorded write |
| wp_n | input | 1 | Write protect, active low; blocks data-register writes |
| op_valid | input | 1 | One-cycle operation strobe |
| op_code | input | 3 | Opcode 0..7, as listed in R2, R3, R4, R5 and R10 |
| pot_sel | input | 1 | Channel index |
| reg_sel | input | 2 | Data register index |
| wr_data | input | 8 | Data byte for write opcodes |
| rd_data | output | 8 | Registered read result |
| wiper_code | output | 16 | Wiper codes, channel p at bits [p*8 +: 8] |
| tap_sel | output | 512 | One-hot tap selects, channel p at bits [p*256 +: 256] |
| wip | output | 1 | Write in progress |

## Verification
The bench targets the window between recording a data write and the end of its timed cycle. It reads the register while the write is recorded and again while it is busy. A design that commits early would return the new value in those reads, and one that counts the cycle wrong would give a `wip` pulse of the wrong length. Write protect is dropped at three points: at request time, while the write waits for chip select, and on the very clock where chip select is released. It is dropped once more after the cycle has started. A design with these priorities wrong would either store protected data or lose a write that had already begun. A second request during a busy cycle, a strobe with chip select high, and taps at codes 0 and 255 catch designs that chain cycles, act on deselected strobes, or mis-decode the end taps. A reset after data register 0 is written checks that the wipers are recalled rather than cleared.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
  typedef enum logic [2:0] {
    OP_RD_WIPER = 3'd0,
    OP_WR_WIPER = 3'd1,
    OP_RD_DATA  = 3'd2,
    OP_WR_DATA  = 3'd3,
    OP_XFR_D2W  = 3'd4,
    OP_XFR_W2D  = 3'd5,
    OP_GXFR_D2W = 3'd6,
    OP_GXFR_W2D = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    NV_IDLE  = 2'd0,
    NV_ARMED = 2'd1,
    NV_BUSY  = 2'd2
  } nv_state_e;
endpackage

// File: rtl/dwb_tap_decode.sv
module dwb_tap_decode #(
  parameter int CODE_W = 8,
  localparam int TAPS = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code,
  output logic [TAPS-1:0]   tap
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tap[i] = (code == CODE_W'(i));
  end
endmodule

// File: rtl/dwb_channel.sv
module dwb_channel #(
  parameter int CODE_W = 8,
  parameter int NREG   = 4,
  localparam int IDX_W = $clog2(NREG),
  localparam int TAPS  = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              recall,
  input  logic              wiper_we,
  input  logic [CODE_W-1:0] wiper_wdata,
  input  logic              dr_we,
  input  logic [IDX_W-1:0]  dr_widx,
  input  logic [CODE_W-1:0] dr_wdata,
  input  logic [IDX_W-1:0]  dr_ridx,
  output logic [CODE_W-1:0] dr_rdata,
  output logic [CODE_W-1:0] wiper,
  output logic [TAPS-1:0]   tap_sel
);
  logic [CODE_W-1:0] store_q [NREG];
  logic [CODE_W-1:0] wiper_d, wiper_q;
  logic              wiper_en;

  // storage cells model nonvolatile memory: no reset
  always_ff @(posedge clk) begin
    if (dr_we) store_q[dr_widx] <= dr_wdata;
  end

  assign dr_rdata = store_q[dr_ridx];

  always_comb begin
    wiper_en = recall | wiper_we;
    wiper_d  = recall ? store_q[0] : wiper_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wiper_q <= '0;
    else if (wiper_en) wiper_q <= wiper_d;
  end

  assign wiper = wiper_q;

  dwb_tap_decode #(.CODE_W(CODE_W)) u_dec (
    .code (wiper_q),
    .tap  (tap_sel)
  );
endmodule

// File: rtl/dwb_nv_ctrl.sv
module dwb_nv_ctrl
  import dwb_pkg::*;
#(
  parameter int NPOT      = 2,
  parameter int CODE_W    = 8,
  parameter int IDX_W     = 2,
  parameter int WR_CYCLES = 1250000,
  localparam int CNT_W    = $clog2(WR_CYCLES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   wp_n,
  input  logic                   req,
  input  logic [NPOT-1:0]        req_mask,
  input  logic [IDX_W-1:0]       req_idx,
  input  logic [NPOT*CODE_W-1:0] req_data,
  output logic                   commit,
  output logic [NPOT-1:0]        commit_mask,
  output logic [IDX_W-1:0]       commit_idx,
  output logic [NPOT*CODE_W-1:0] commit_data,
  output logic                   wip
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

  nv_state_e          state_d, state_q;
  logic [CNT_W-1:0]   cnt_d, cnt_q;
  logic               cap_en;
  logic [NPOT-1:0]        mask_q;
  logic [IDX_W-1:0]       idx_q;
  logic [NPOT*CODE_W-1:0] data_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cap_en  = 1'b0;
    case (state_q)
      NV_IDLE: begin
        if (req && wp_n) begin
          state_d = NV_ARMED;
          cap_en  = 1'b1;
        end
      end
      NV_ARMED: begin
        if (!wp_n) begin
          state_d = NV_IDLE;
        end else if (cs_n) begin
          state_d = NV_BUSY;
          cnt_d   = '0;
        end else if (req) begin
          cap_en  = 1'b1;
        end
      end
      NV_BUSY: begin
        if (cnt_q == LAST) state_d = NV_IDLE;
        else               cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = NV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= NV_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      idx_q  <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      mask_q <= req_mask;
      idx_q  <= req_idx;
      data_q <= req_data;
    end
  end

  assign wip         = (state_q == NV_BUSY);
  assign commit      = wip && (cnt_q == LAST);
  assign commit_mask = mask_q;
  assign commit_idx  = idx_q;
  assign commit_data = data_q;
endmodule

// File: rtl/dual_wiper_bank.sv
module dual_wiper_bank
  import dwb_pkg::*;
#(
  parameter int NPOT      = 2,
  parameter int CODE_W    = 8,
  parameter int NREG      = 4,
  parameter int WR_CYCLES = 1250000,
  localparam int IDX_W    = $clog2(NREG),
  localparam int POT_W    = (NPOT > 1) ? $clog2(NPOT) : 1,
  localparam int TAPS     = 1 << CODE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   wp_n,
  input  logic                   op_valid,
  input  logic [2:0]             op_code,
  input  logic [POT_W-1:0]       pot_sel,
  input  logic [IDX_W-1:0]       reg_sel,
  input  logic [CODE_W-1:0]      wr_data,
  output logic [CODE_W-1:0]      rd_data,
  output logic [NPOT*CODE_W-1:0] wiper_code,
  output logic [NPOT*TAPS-1:0]   tap_sel,
  output logic                   wip
);
  logic rst_s1, rst_s;
  logic recall_q;
  op_e  op;
  logic op_fire;

  logic [CODE_W-1:0]      wiper_a   [NPOT];
  logic [CODE_W-1:0]      dr_rd_a   [NPOT];
  logic [CODE_W-1:0]      wiper_wd  [NPOT];
  logic [NPOT-1:0]        wiper_we;
  logic                   nv_req;
  logic [NPOT-1:0]        nv_mask;
  logic [NPOT*CODE_W-1:0] nv_data;
  logic                   commit;
  logic [NPOT-1:0]        commit_mask;
  logic [IDX_W-1:0]       commit_idx;
  logic [NPOT*CODE_W-1:0] commit_data;
  logic [CODE_W-1:0]      rd_d, rd_q;
  logic                   rd_en;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s  <= rst_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) recall_q <= 1'b1;
    else        recall_q <= 1'b0;
  end

  assign op      = op_e'(op_code);
  assign op_fire = op_valid && !cs_n && !recall_q;

  for (genvar p = 0; p < NPOT; p++) begin : g_pot
    logic sel;
    assign sel = (pot_sel == POT_W'(p));

    always_comb begin
      wiper_we[p] = op_fire && ((sel && (op == OP_WR_WIPER || op == OP_XFR_D2W))
                                || op == OP_GXFR_D2W);
      wiper_wd[p] = (op == OP_WR_WIPER) ? wr_data : dr_rd_a[p];
      nv_mask[p]  = sel || (op == OP_GXFR_W2D);
      nv_data[p*CODE_W +: CODE_W] = (op == OP_WR_DATA) ? wr_data : wiper_a[p];
    end

    dwb_channel #(.CODE_W(CODE_W), .NREG(NREG)) u_chan (
      .clk         (clk),
      .rst_n       (rst_s),
      .recall      (recall_q),
      .wiper_we    (wiper_we[p]),
      .wiper_wdata (wiper_wd[p]),
      .dr_we       (commit && commit_mask[p]),
      .dr_widx     (commit_idx),
      .dr_wdata    (commit_data[p*CODE_W +: CODE_W]),
      .dr_ridx     (reg_sel),
      .dr_rdata    (dr_rd_a[p]),
      .wiper       (wiper_a[p]),
      .tap_sel     (tap_sel[p*TAPS +: TAPS])
    );

    assign wiper_code[p*CODE_W +: CODE_W] = wiper_a[p];
  end

  assign nv_req = op_fire &&
                  (op == OP_WR_DATA || op == OP_XFR_W2D || op == OP_GXFR_W2D);

  dwb_nv_ctrl #(
    .NPOT      (NPOT),
    .CODE_W    (CODE_W),
    .IDX_W     (IDX_W),
    .WR_CYCLES (WR_CYCLES)
  ) u_nv (
    .clk         (clk),
    .rst_n       (rst_s),
    .cs_n        (cs_n),
    .wp_n        (wp_n),
    .req         (nv_req),
    .req_mask    (nv_mask),
    .req_idx     (reg_sel),
    .req_data    (nv_data),
    .commit      (commit),
    .commit_mask (commit_mask),
    .commit_idx  (commit_idx),
    .commit_data (commit_data),
    .wip         (wip)
  );

  always_comb begin
    rd_en = op_fire && (op == OP_RD_WIPER || op == OP_RD_DATA);
    rd_d  = (op == OP_RD_WIPER) ? wiper_a[pot_sel] : dr_rd_a[pot_sel];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/dwb_checker.sv
module dwb_checker #(
  parameter int NPOT      = 2,
  parameter int CODE_W    = 8,
  parameter int WR_CYCLES = 1250000,
  localparam int TAPS     = 1 << CODE_W,
  localparam int RUN_W    = $clog2(WR_CYCLES + 1) + 1
) (
  input logic                   clk,
  input logic                   rst_s,
  input logic                   cs_n,
  input logic                   wp_n,
  input logic                   op_valid,
  input logic                   recall_q,
  input logic                   wip,
  input logic [NPOT*CODE_W-1:0] wiper_code,
  input logic [NPOT*TAPS-1:0]   tap_sel
);
  logic [RUN_W-1:0] wip_run;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)   wip_run <= '0;
    else if (wip) wip_run <= wip_run + 1'b1;
    else          wip_run <= '0;
  end

  AST_WIP_LENGTH: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(wip) |-> (wip_run == RUN_W'(WR_CYCLES))); // R3

  AST_WIP_AFTER_CS_RISE: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(wip) |-> ($past(cs_n) && !$past(cs_n, 2))); // R3

  AST_WIP_NEEDS_WP: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(wip) |-> $past(wp_n)); // R6

  AST_WIPER_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    (!$past(op_valid && !cs_n) && !$past(recall_q)) |-> $stable(wiper_code)); // R10

  for (genvar p = 0; p < NPOT; p++) begin : g_chk
    AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_s)
      $onehot(tap_sel[p*TAPS +: TAPS])); // R9
  end
endmodule

bind dual_wiper_bank dwb_checker #(
  .NPOT      (NPOT),
  .CODE_W    (CODE_W),
  .WR_CYCLES (WR_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .cs_n       (cs_n),
  .wp_n       (wp_n),
  .op_valid   (op_valid),
  .recall_q   (recall_q),
  .wip        (wip),
  .wiper_code (wiper_code),
  .tap_sel    (tap_sel)
);

// File: tb/dual_wiper_bank_bench.sv
module dual_wiper_bank_bench;
  localparam int WRC = 16;

  logic         clk = 1'b0;
  logic         rst_n, cs_n, wp_n, op_valid;
  logic [2:0]   op_code;
  logic [0:0]   pot_sel;
  logic [1:0]   reg_sel;
  logic [7:0]   wr_data, rd_data;
  logic [15:0]  wiper_code;
  logic [511:0] tap_sel;
  logic         wip;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  dual_wiper_bank #(.WR_CYCLES(WRC)) u_dual_wiper_bank (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .op_valid(op_valid),
    .op_code(op_code), .pot_sel(pot_sel), .reg_sel(reg_sel), .wr_data(wr_data),
    .rd_data(rd_data), .wiper_code(wiper_code), .tap_sel(tap_sel), .wip(wip)
  );

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic check(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic int wiper_of(input int p);
    return int'(wiper_code[p*8 +: 8]);
  endfunction

  task automatic check_tap(input string req, input int p, input int code);
    check(req, $countones(tap_sel[p*256 +: 256]), 1);
    check(req, int'(tap_sel[p*256 + code]), 1);
  endtask

  task automatic issue(input logic [2:0] op, input int p, input int r, input logic [7:0] d);
    op_valid = 1'b1; op_code = op; pot_sel = p[0:0]; reg_sel = r[1:0]; wr_data = d;
    tick;
    op_valid = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (wip && n < 1000) begin n++; tick; end
  endtask

  task automatic read_op(input logic [2:0] op, input int p, input int r, output int v);
    cs_n = 1'b0; tick;
    issue(op, p, r, 8'h00);
    v = int'(rd_data);
    cs_n = 1'b1; tick;
  endtask

  task automatic nv_write(input logic [2:0] op, input int p, input int r,
                          input logic [7:0] d, output int busy);
    cs_n = 1'b0; tick;
    issue(op, p, r, d);
    cs_n = 1'b1; tick;
    wait_idle(busy);
  endtask

  task automatic session_op(input logic [2:0] op, input int p, input int r, input logic [7:0] d);
    cs_n = 1'b0; tick;
    issue(op, p, r, d);
    cs_n = 1'b1; tick;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; cs_n = 1'b1; op_valid = 1'b0;
    repeat (3) tick;
    rst_n = 1'b1;
    repeat (5) tick;
  endtask

  task automatic t_reset;
    int n;
    do_reset;
    check("R1 wip after reset", int'(wip), 0);
    check("R1 rd_data after reset", int'(rd_data), 0);
    nv_write(3'd3, 0, 0, 8'h5A, n);
    check("R3 busy length", n, WRC);
    nv_write(3'd3, 1, 0, 8'hC3, n);
    do_reset;
    check("R1 recall pot0", wiper_of(0), 'h5A);
    check("R1 recall pot1", wiper_of(1), 'hC3);
    check_tap("R9 tap pot0", 0, 'h5A);
    check_tap("R9 tap pot1", 1, 'hC3);
  endtask

  task automatic t_wiper_write;
    wp_n = 1'b0;
    session_op(3'd1, 1, 0, 8'h80);
    check("R2 wiper write pot1", wiper_of(1), 'h80);
    check("R2 other pot kept", wiper_of(0), 'h5A);
    check_tap("R9 tap after write", 1, 'h80);
    wp_n = 1'b1;
  endtask

  task automatic t_deferred;
    int n, v;
    nv_write(3'd3, 0, 2, 8'h11, n);
    cs_n = 1'b0; tick;
    issue(3'd3, 0, 2, 8'h33);
    issue(3'd2, 0, 2, 8'h00);
    check("R3 old value while recorded", int'(rd_data), 'h11);
    cs_n = 1'b1; tick;
    check("R3 wip raised", int'(wip), 1);
    cs_n = 1'b0; tick;
    issue(3'd2, 0, 2, 8'h00);
    check("R3 old value while busy", int'(rd_data), 'h11);
    cs_n = 1'b1; tick;
    wait_idle(n);
    read_op(3'd2, 0, 2, v);
    check("R3 new value after cycle", v, 'h33);
  endtask

  task automatic t_single_xfr;
    int n, v;
    session_op(3'd4, 0, 2, 8'h00);
    check("R4 data to wiper", wiper_of(0), 'h33);
    session_op(3'd1, 1, 0, 8'h9C);
    nv_write(3'd5, 1, 3, 8'h00, n);
    check("R4 wiper to data busy", n, WRC);
    read_op(3'd2, 1, 3, v);
    check("R4 wiper to data value", v, 'h9C);
  endtask

  task automatic t_global;
    int n, v;
    nv_write(3'd7, 0, 1, 8'h00, n);
    check("R5 global store busy", n, WRC);
    read_op(3'd2, 0, 1, v);
    check("R5 global store pot0", v, 'h33);
    read_op(3'd2, 1, 1, v);
    check("R5 global store pot1", v, 'h9C);
    session_op(3'd1, 0, 0, 8'h01);
    session_op(3'd1, 1, 0, 8'h02);
    session_op(3'd6, 0, 1, 8'h00);
    check("R5 global load pot0", wiper_of(0), 'h33);
    check("R5 global load pot1", wiper_of(1), 'h9C);
  endtask

  task automatic t_protect;
    int n, v;
    wp_n = 1'b0;
    nv_write(3'd3, 0, 1, 8'hEE, n);
    check("R6 protected request no cycle", n, 0);
    wp_n = 1'b1;
    cs_n = 1'b0; tick;
    issue(3'd3, 0, 1, 8'hEE);
    wp_n = 1'b0; tick;
    wp_n = 1'b1; tick;
    cs_n = 1'b1; tick; tick;
    check("R6 cancel while selected", int'(wip), 0);
    cs_n = 1'b0; tick;
    issue(3'd3, 0, 1, 8'hEE);
    cs_n = 1'b1; wp_n = 1'b0; tick;
    wp_n = 1'b1; tick;
    check("R6 cancel at release", int'(wip), 0);
    read_op(3'd2, 0, 1, v);
    check("R6 register kept", v, 'h33);
  endtask

  task automatic t_protect_late;
    int n, v;
    session_op(3'd3, 1, 1, 8'hA7);
    check("R7 cycle started", int'(wip), 1);
    wp_n = 1'b0;
    wait_idle(n);
    wp_n = 1'b1;
    read_op(3'd2, 1, 1, v);
    check("R7 value stored", v, 'hA7);
  endtask

  task automatic t_busy_reject;
    int n, v;
    session_op(3'd3, 0, 3, 8'h44);
    check("R8 first cycle", int'(wip), 1);
    session_op(3'd3, 0, 3, 8'h55);
    wait_idle(n);
    repeat (3) tick;
    check("R8 no second cycle", int'(wip), 0);
    read_op(3'd2, 0, 3, v);
    check("R8 register keeps first", v, 'h44);
  endtask

  task automatic t_select_and_read;
    int v;
    cs_n = 1'b1;
    issue(3'd1, 0, 0, 8'hFF);
    check("R10 deselected strobe ignored", wiper_of(0), 'h33);
    session_op(3'd1, 0, 0, 8'hFF);
    check_tap("R9 tap code 255", 0, 255);
    session_op(3'd1, 1, 0, 8'h00);
    check_tap("R9 tap code 0", 1, 0);
    read_op(3'd0, 0, 0, v);
    check("R10 read wiper", v, 'hFF);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; wp_n = 1'b1; op_valid = 1'b0;
    op_code = '0; pot_sel = '0; reg_sel = '0; wr_data = '0;
    t_reset;
    t_wiper_write;
    t_deferred;
    t_single_xfr;
    t_global;
    t_protect;
    t_protect_late;
    t_busy_reject;
    t_select_and_read;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule